// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM and owns the command bus from reset until the memory is ready for traffic. After reset it holds the clock-enable low for a settling time of `CLK_MHZ * STABLE_US` cycles. It then raises clock-enable with a NOP and walks a fixed chain of commands. The chain is: precharge of all banks, extended mode write that turns the DLL on, mode write with the DLL-reset bit, a second precharge of all banks, a run of auto-refreshes, and a final mode write with the DLL-reset bit cleared. Each command is separated by its own minimum gap, and every gap is a parameter counted in clock cycles.

The user of the block supplies the burst length, the burst type, the CAS latency and the output drive selection as static inputs. The sequencer merges them into the mode register writes. A second counter starts at the DLL-reset write and runs alongside the later steps. The ready flag rises only when the gap after the final mode write has elapsed and the DLL has had its lock time. From then on the bus carries NOP until the rest of the controller takes over.

Top module: `ddr_init_seq`

## Requirements
- R1: During reset, and for exactly `CLK_MHZ*STABLE_US` cycles after reset is released, `cke` is low and the bus carries NOP. NOP is cs_n=0, ras_n=1, cas_n=1, we_n=1, with ba=0 and addr=0.
- R2: In the next cycle `cke` rises together with a NOP, and it stays high from then on. The cycle after that carries a precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, with only `addr[AP_BIT]` set (bit 10 by default).
- R3: `T_RP` cycles after the first precharge-all, an extended mode write is issued: cs_n, ras_n, cas_n and we_n all 0, with ba=2'b01. addr[0]=0 enables the DLL, addr[1]=drive_sel[0], addr[6]=drive_sel[1], and every other address bit is 0.
- R4: `T_MRD` cycles after the extended write, a mode write is issued with ba=2'b00, addr[8]=1 (DLL reset) and addr[7]=0. It carries the same mode fields as R7 in addr[6:0].
- R5: `T_MRD` cycles after the DLL-reset write, a second precharge-all is issued, encoded as in R2.
- R6: `REFRESH_COUNT` auto-refreshes follow, encoded as cs_n=0, ras_n=0, cas_n=0, we_n=1 with addr=0 and ba=0. The first comes `T_RP` cycles after the second precharge-all, and each later one comes `T_RFC` cycles after the one before.
- R7: `T_RFC` cycles after the last refresh, the final mode write is issued. It has ba=2'b00 and addr[10:7]=0. addr[6:4] equals `cas_lat` in binary (3→011, 4→100, 5→101). addr[3] equals `burst_interleave`. addr[2:0] is the burst code for `bl_sel`: 0→001 (2), 1→010 (4), 2→011 (8), 3→111 (full page).
- R8: Every cycle that is not one of the commands above carries NOP, so each command is followed by at least one NOP.
- R9: `init_done` is low until the later of two cycles: the final mode write plus `T_MRD`, and the DLL-reset write plus `DLL_LOCK`. It rises at that cycle and stays high with NOP on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset, restarts the sequence |
| bl_sel | input | 2 | Burst length select: 0=2, 1=4, 2=8, 3=full page |
| burst_interleave | input | 1 | Burst type: 0 sequential, 1 interleaved |
| cas_lat | input | 3 | CAS latency in cycles, 3 to 5 |
| drive_sel | input | 2 | Output drive selection, bit 0 to addr[1], bit 1 to addr[6] |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus (11 bits by default) |
| init_done | output | 1 | Initialization complete |

## Verification
The bench walks every combination of burst length select, burst type, legal CAS latency and drive selection. Each combination gets a fresh reset, and the whole bus is compared with an arithmetic schedule in every cycle, so a mode field landing in the wrong bit or a wrong command cycle shows up. Two instances with different timing run side by side. In one, the DLL lock time ends after the final mode-write gap, so the ready flag waits for the lock counter. In the other, the lock time ends first, so the ready flag follows the command chain. This separates the two conditions behind R9. The different refresh counts and precharge gaps of the two instances also show whether the refresh count and gaps follow their parameters.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int CLK_MHZ       = 166,
  parameter int STABLE_US     = 200,
  parameter int T_RP          = 3,
  parameter int T_RFC         = 12,
  parameter int T_MRD         = 2,
  parameter int DLL_LOCK      = 200,
  parameter int REFRESH_COUNT = 2,
  parameter int ADDR_W        = 11,
  parameter int AP_BIT        = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bl_sel,
  input  logic              burst_interleave,
  input  logic [2:0]        cas_lat,
  input  logic [1:0]        drive_sel,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
  localparam int SW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
  localparam int WAIT_MAX = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                           : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int WW = $clog2(WAIT_MAX + 1);
  localparam int LW = $clog2(DLL_LOCK + 1);
  localparam int RW = $clog2(REFRESH_COUNT + 1);

  localparam logic [SW-1:0] STAB_LAST = SW'(STABLE_CYC - 1);
  localparam logic [WW-1:0] LD_RP  = WW'(T_RP - 2);
  localparam logic [WW-1:0] LD_RFC = WW'(T_RFC - 2);
  localparam logic [WW-1:0] LD_MRD = WW'(T_MRD - 2);
  localparam logic [LW-1:0] LD_LOCK = LW'(DLL_LOCK - 2);
  localparam logic [RW-1:0] REF_LAST = RW'(REFRESH_COUNT - 1);

  typedef enum logic [3:0] {
    ST_STABLE, ST_CKE, ST_PRE1, ST_EMRS, ST_MRS_DLL,
    ST_PRE2, ST_REF, ST_MRS_FIN, ST_WAIT, ST_DONE
  } st_t;

  st_t           state, ret_st;
  logic [SW-1:0] stab_cnt;
  logic [WW-1:0] wait_cnt;
  logic [LW-1:0] lock_cnt;
  logic [RW-1:0] ref_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_STABLE;
      ret_st   <= ST_STABLE;
      stab_cnt <= '0;
      wait_cnt <= '0;
      lock_cnt <= '0;
      ref_cnt  <= '0;
    end else begin
      if (lock_cnt != '0) lock_cnt <= lock_cnt - 1'b1;
      case (state)
        ST_STABLE: begin
          if (stab_cnt == STAB_LAST) state <= ST_CKE;
          else stab_cnt <= stab_cnt + 1'b1;
        end
        ST_CKE: state <= ST_PRE1;
        ST_PRE1: begin
          wait_cnt <= LD_RP;  ret_st <= ST_EMRS;    state <= ST_WAIT;
        end
        ST_EMRS: begin
          wait_cnt <= LD_MRD; ret_st <= ST_MRS_DLL; state <= ST_WAIT;
        end
        ST_MRS_DLL: begin
          wait_cnt <= LD_MRD; ret_st <= ST_PRE2;    state <= ST_WAIT;
          lock_cnt <= LD_LOCK;
        end
        ST_PRE2: begin
          wait_cnt <= LD_RP;  ret_st <= ST_REF;     state <= ST_WAIT;
        end
        ST_REF: begin
          ref_cnt  <= ref_cnt + 1'b1;
          wait_cnt <= LD_RFC;
          ret_st   <= (ref_cnt == REF_LAST) ? ST_MRS_FIN : ST_REF;
          state    <= ST_WAIT;
        end
        ST_MRS_FIN: begin
          wait_cnt <= LD_MRD; ret_st <= ST_DONE;    state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
          else if (ret_st != ST_DONE || lock_cnt == '0) state <= ret_st;
        end
        ST_DONE: state <= ST_DONE;
        default: state <= ST_STABLE;
      endcase
    end
  end

  logic [2:0] bl_code;
  logic [6:0] mode_bits;
  assign bl_code   = (bl_sel == 2'd3) ? 3'b111 : ({1'b0, bl_sel} + 3'd1);
  assign mode_bits = {cas_lat, burst_interleave, bl_code};

  assign cke       = (state != ST_STABLE);
  assign init_done = (state == ST_DONE);

  always_comb begin
    cs_n  = 1'b0;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    ba    = 2'b00;
    addr  = '0;
    case (state)
      ST_PRE1, ST_PRE2: begin
        ras_n = 1'b0;
        we_n  = 1'b0;
        addr[AP_BIT] = 1'b1;
      end
      ST_EMRS: begin
        {ras_n, cas_n, we_n} = 3'b000;
        ba      = 2'b01;
        addr[1] = drive_sel[0];
        addr[6] = drive_sel[1];
      end
      ST_MRS_DLL: begin
        {ras_n, cas_n, we_n} = 3'b000;
        addr[6:0] = mode_bits;
        addr[8]   = 1'b1;
      end
      ST_REF: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
      end
      ST_MRS_FIN: begin
        {ras_n, cas_n, we_n} = 3'b000;
        addr[6:0] = mode_bits;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int ADDR_W = 11,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);

  logic is_nop, is_pre, is_ref, is_mrw;
  assign is_nop = !cs_n && ras_n && cas_n && we_n;
  assign is_pre = !cs_n && !ras_n && cas_n && !we_n;
  assign is_ref = !cs_n && !ras_n && !cas_n && we_n;
  assign is_mrw = !cs_n && !ras_n && !cas_n && !we_n;

  p_nop_while_cke_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> is_nop);

  p_cke_stays_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  p_precharge_after_cke_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |=> (is_pre && addr[AP_BIT]));

  p_ext_write_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrw && ba == 2'b01) |-> (addr[0] == 1'b0 && addr[5:2] == 4'd0 && addr[10:7] == 4'd0));

  p_mode_write_test_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrw && ba == 2'b00) |-> (addr[7] == 1'b0 && addr[10:9] == 2'd0));

  p_refresh_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (addr == '0 && ba == 2'b00));

  p_gap_after_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |=> is_nop);

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (is_nop && cke));

endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
);

// File: tb/ddr_init_seq_tb.sv
`timescale 1ns/1ps
module ddr_init_seq_tb;

  localparam int A_MHZ = 1, A_US = 6, A_RP = 3, A_RFC = 5, A_MRD = 2, A_LOCK = 20, A_NREF = 2;
  localparam int B_MHZ = 2, B_US = 2, B_RP = 2, B_RFC = 5, B_MRD = 2, B_LOCK = 8,  B_NREF = 3;
  localparam int LAST_K = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bl_sel = '0;
  logic burst_interleave = 1'b0;
  logic [2:0] cas_lat = 3'd3;
  logic [1:0] drive_sel = '0;

  logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic [1:0] a_ba;
  logic [10:0] a_addr;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0] b_ba;
  logic [10:0] b_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ddr_init_seq #(.CLK_MHZ(A_MHZ), .STABLE_US(A_US), .T_RP(A_RP), .T_RFC(A_RFC),
                 .T_MRD(A_MRD), .DLL_LOCK(A_LOCK), .REFRESH_COUNT(A_NREF)) u_dut (
    .clk(clk), .rst_n(rst_n), .bl_sel(bl_sel), .burst_interleave(burst_interleave),
    .cas_lat(cas_lat), .drive_sel(drive_sel), .cke(a_cke), .cs_n(a_cs), .ras_n(a_ras),
    .cas_n(a_cas), .we_n(a_we), .ba(a_ba), .addr(a_addr), .init_done(a_done));

  ddr_init_seq #(.CLK_MHZ(B_MHZ), .STABLE_US(B_US), .T_RP(B_RP), .T_RFC(B_RFC),
                 .T_MRD(B_MRD), .DLL_LOCK(B_LOCK), .REFRESH_COUNT(B_NREF)) u_alt (
    .clk(clk), .rst_n(rst_n), .bl_sel(bl_sel), .burst_interleave(burst_interleave),
    .cas_lat(cas_lat), .drive_sel(drive_sel), .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras),
    .cas_n(b_cas), .we_n(b_we), .ba(b_ba), .addr(b_addr), .init_done(b_done));

  // vector: {cke, cs_n, ras_n, cas_n, we_n, ba[1:0], addr[10:0], init_done}
  function automatic logic [18:0] expv(input int k, input int s, input int rp, input int rfc,
                                       input int mrd, input int lock, input int nref,
                                       output string req);
    logic cke_e, done_e;
    logic [3:0] cmd;
    logic [1:0] ba_e;
    logic [10:0] ad;
    logic [2:0] bcode;
    int p1, e, m1, p2, r0, mf, dn;
    p1 = s + 1; e = p1 + rp; m1 = e + mrd; p2 = m1 + mrd; r0 = p2 + rp;
    mf = r0 + nref * rfc;
    dn = (mf + mrd > m1 + lock) ? mf + mrd : m1 + lock;
    bcode = (bl_sel == 2'd3) ? 3'b111 : 3'(bl_sel + 1);
    cke_e = (k >= s);
    done_e = (k >= dn);
    cmd = 4'b0111; ba_e = 2'b00; ad = '0;
    req = (k < s) ? "R1" : (done_e ? "R9" : "R8");
    if (k == s) req = "R2";
    if (k == p1 || k == p2) begin
      cmd = 4'b0010; ad[10] = 1'b1; req = (k == p1) ? "R2" : "R5";
    end
    if (k == e) begin
      cmd = 4'b0000; ba_e = 2'b01; ad[1] = drive_sel[0]; ad[6] = drive_sel[1]; req = "R3";
    end
    if (k == m1) begin
      cmd = 4'b0000; ad[6:0] = {cas_lat, burst_interleave, bcode}; ad[8] = 1'b1; req = "R4";
    end
    for (int i = 0; i < nref; i++)
      if (k == r0 + i * rfc) begin cmd = 4'b0001; req = "R6"; end
    if (k == mf) begin
      cmd = 4'b0000; ad[6:0] = {cas_lat, burst_interleave, bcode}; req = "R7";
    end
    if (k == dn) req = "R9";
    return {cke_e, cmd, ba_e, ad, done_e};
  endfunction

  task automatic check_both(input int k);
    string ra, rb;
    logic [18:0] ea, eb, ga, gb;
    ea = expv(k, A_MHZ * A_US, A_RP, A_RFC, A_MRD, A_LOCK, A_NREF, ra);
    eb = expv(k, B_MHZ * B_US, B_RP, B_RFC, B_MRD, B_LOCK, B_NREF, rb);
    ga = {a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done};
    gb = {b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done};
    checks += 2;
    if (ga !== ea) begin
      errors++;
      $display("FAIL %s u_dut cycle %0d bl=%0d it=%0d cl=%0d drv=%0d got %h exp %h",
               ra, k, bl_sel, burst_interleave, cas_lat, drive_sel, ga, ea);
    end
    if (gb !== eb) begin
      errors++;
      $display("FAIL %s u_alt cycle %0d bl=%0d it=%0d cl=%0d drv=%0d got %h exp %h",
               rb, k, bl_sel, burst_interleave, cas_lat, drive_sel, gb, eb);
    end
  endtask

  task automatic run_one(input logic [1:0] bl, input logic it, input logic [2:0] cl,
                         input logic [1:0] drv);
    rst_n = 1'b0;
    bl_sel = bl; burst_interleave = it; cas_lat = cl; drive_sel = drv;
    repeat (3) @(negedge clk);
    check_both(0);  // R1: reset state equals the first settling cycle
    rst_n = 1'b1;
    check_both(0);
    for (int k = 1; k <= LAST_K; k++) begin
      @(negedge clk);
      check_both(k);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, got running expected finished");
      summary();
    end
  end

  initial begin
    for (int b = 0; b < 4; b++)
      for (int t = 0; t < 2; t++)
        for (int c = 3; c <= 5; c++)
          for (int d = 0; d < 4; d++)
            run_one(2'(b), 1'(t), 3'(c), 2'(d));
    summary();
  end

endmodule